// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC. It places incoming frame bytes into buffers that software has set aside. Software describes each buffer with one entry in a circular table of descriptors. An entry holds the buffer start address, the buffer length coded as length minus one, and a flag that asks for an interrupt.

The block fills the descriptor at its produce index. When that buffer is full, or when the frame ends, the fragment is closed. A status word for the fragment is written through the memory write port. Only after that status write has been issued does the produce index step forward, and the fragment interrupt pulses in that same cycle. Every descriptor from the produce index up to the software consume index belongs to the hardware. A descriptor passes back to software only when the produce index moves past it.

A frame longer than one buffer carries on at offset zero of the next descriptor. Two conditions cause a frame to be discarded:
- If the descriptor that a new fragment needs is not free, the rest of the frame is discarded and a sticky overrun flag is set.
- If either enable is low when a frame starts, the whole frame is discarded. Reception needs both the MAC enable and the datapath enable.

A synchronous soft reset of the receive path clears the produce index and the overrun flag, and abandons any frame in progress. This hands every descriptor back to software.

The control FSM has five states:
- `ST_IDLE`: waits for the first byte of a frame.
- `ST_FILL`: stores the bytes that follow within a fragment.
- `ST_STATUS`: writes the status word and steps the produce index.
- `ST_CONT`: waits for the first byte of a continuation fragment.
- `ST_DROP`: discards bytes up to the end of the frame.

The FSM moves between states as follows:
- From `ST_IDLE` or `ST_CONT`, an accepted byte on a usable descriptor goes to `ST_FILL`. It goes to `ST_STATUS` instead when that byte is last or fills the buffer.
- From `ST_IDLE` or `ST_CONT`, a refused start goes to `ST_DROP`, or stays out of it when the byte is last.
- From `ST_FILL`, the move to `ST_STATUS` happens on the last byte or on a full buffer.
- From `ST_STATUS`, the FSM goes to `ST_IDLE` after a last fragment and to `ST_CONT` otherwise.
- From `ST_DROP`, the FSM goes to `ST_IDLE` on the frame's last byte.
- Soft reset forces `ST_IDLE` from any state.

Top module: `rxring_writer`

## Requirements
- R1: After reset (and after soft reset), `prod_idx` is 0, `overrun` is 0, `frag_irq` is 0, `rx_ready` is 1 and no memory write is issued.
- R2: The k-th byte (from 0) of a fragment is written with `mem_word`=0 to address descriptor pointer + k, with the byte in `mem_wdata[7:0]` and zeros above it, in the cycle it is accepted.
- R3: A frame whose first byte arrives while `mac_en` or `path_en` is low produces no memory write and no index change.
- R4: A fragment closes when its byte count reaches the coded size plus one, or at the frame's last byte. Its status word is written with `mem_word`=1 to `stat_base` + 4 × index. The status word holds the byte count in bits 15:0, and bit 31 is set only for the fragment holding the frame's last byte.
- R5: `prod_idx` advances by exactly one, modulo the ring size, in the cycle after a status write, and at no other time except soft reset.
- R6: `frag_irq` pulses for one cycle, together with the index advance, when the closed descriptor's interrupt flag is set. It stays low otherwise.
- R7: A frame longer than its buffer continues at offset 0 of the next descriptor.
- R8: If the descriptor needed for a new fragment is not free (produce index plus one, modulo the ring size, equals `cons_idx`), nothing is written for the rest of the frame and `overrun` becomes 1. It stays 1 until soft reset.
- R9: `rx_ready` is low in exactly the status-write cycle.
- R10: Soft reset abandons a frame in progress, sets `prod_idx` to 0 and clears `overrun`. The next byte starts a new frame at descriptor 0.
- R11: The produce index wraps from the last descriptor to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous receive-path reset |
| mac_en | input | 1 | MAC-level receive enable |
| path_en | input | 1 | Datapath-level receive enable |
| desc_wr | input | 1 | Descriptor table write strobe |
| desc_wr_idx | input | IDX_W | Descriptor being written |
| desc_wr_ptr | input | AW | Buffer start address |
| desc_wr_size_m1 | input | SIZE_W | Buffer length minus one |
| desc_wr_irq | input | 1 | Interrupt request flag |
| stat_base | input | AW | Base address of the status word array |
| cons_idx | input | IDX_W | Software consume index |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_ready | output | 1 | Byte accepted when high together with valid |
| mem_we | output | 1 | Memory write strobe |
| mem_word | output | 1 | 1: 32-bit status word, 0: byte in bits 7:0 |
| mem_addr | output | AW | Write address |
| mem_wdata | output | 32 | Write data |
| prod_idx | output | IDX_W | Produce index |
| frag_irq | output | 1 | Fragment-complete interrupt pulse |
| overrun | output | 1 | Sticky ring-full drop flag |

## Verification
The bench drives frames that are shorter than, exactly equal to, and longer than their buffers. A design that decides "full" one byte early or late would place bytes at the wrong offsets, or close a fragment with the wrong count or last bit. The bench fills the ring until the descriptor just behind the consume index is reached, both in the middle of a frame and at a frame start. A wrong full test would write into a descriptor that software still owns, or would miss the overrun. Further cases cover:
- a frame that starts with only one enable set;
- the index wrap from the last descriptor to 0;
- a soft reset in the middle of a frame, which a faulty design would follow by resuming at the old index or offset, or by keeping the stale overrun flag.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_STATUS,
        ST_CONT,
        ST_DROP
    } rx_state_e;

    localparam int STAT_LAST_BIT = 31;
    localparam int STAT_CNT_W    = 16;
endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table #(
    parameter int N_DESC = 8,
    parameter int IDX_W  = 3,
    parameter int AW     = 32,
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [SIZE_W-1:0] wr_size_m1,
    input  logic              wr_irq,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [AW-1:0]     rd_ptr,
    output logic [SIZE_W-1:0] rd_size_m1,
    output logic              rd_irq
);
    logic [AW-1:0]     ptr_r  [N_DESC];
    logic [SIZE_W-1:0] size_r [N_DESC];
    logic              irq_r  [N_DESC];

    for (genvar g = 0; g < N_DESC; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_r[g]  <= '0;
                size_r[g] <= '0;
                irq_r[g]  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ptr_r[g]  <= wr_ptr;
                size_r[g] <= wr_size_m1;
                irq_r[g]  <= wr_irq;
            end
        end
    end

    always_comb begin
        rd_ptr     = '0;
        rd_size_m1 = '0;
        rd_irq     = 1'b0;
        for (int i = 0; i < N_DESC; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_ptr     = ptr_r[i];
                rd_size_m1 = size_r[i];
                rd_irq     = irq_r[i];
            end
        end
    end
endmodule

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
    parameter int N_DESC = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [IDX_W-1:0] cons_idx,
    output logic [IDX_W-1:0] prod_idx,
    output logic             slot_free
);
    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] prod_nxt;

    if (N_DESC == (1 << IDX_W)) begin : g_pow2
        assign prod_nxt = prod_q + IDX_W'(1);
    end else begin : g_mod
        assign prod_nxt = (prod_q == IDX_W'(N_DESC - 1)) ? '0 : prod_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (clear) begin
            prod_q <= '0;
        end else if (step) begin
            prod_q <= prod_nxt;
        end
    end

    assign prod_idx  = prod_q;
    assign slot_free = (prod_nxt != cons_idx);
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
    parameter int N_DESC = 8,
    parameter int AW     = 32,
    parameter int SIZE_W = 11,
    localparam int IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              mac_en,
    input  logic              path_en,
    input  logic              desc_wr,
    input  logic [IDX_W-1:0]  desc_wr_idx,
    input  logic [AW-1:0]     desc_wr_ptr,
    input  logic [SIZE_W-1:0] desc_wr_size_m1,
    input  logic              desc_wr_irq,
    input  logic [AW-1:0]     stat_base,
    input  logic [IDX_W-1:0]  cons_idx,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_we,
    output logic              mem_word,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [IDX_W-1:0]  prod_idx,
    output logic              frag_irq,
    output logic              overrun
);
    import rxr_pkg::*;

    localparam int CNT_W = SIZE_W + 1;

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_next;
    logic              last_q;
    logic              irq_q;
    logic              ovr_q;

    logic [AW-1:0]     d_ptr;
    logic [SIZE_W-1:0] d_size_m1;
    logic              d_irq;
    logic              slot_free;
    logic              step;

    logic              accept;
    logic              rx_on;
    logic              start_ok;
    logic              buf_full;
    logic              byte_wr;
    logic              ovr_set;
    logic [CNT_W-1:0]  size_cnt;
    logic [AW-1:0]     byte_off;
    logic [31:0]       stat_word;

    rxr_desc_table #(
        .N_DESC (N_DESC),
        .IDX_W  (IDX_W),
        .AW     (AW),
        .SIZE_W (SIZE_W)
    ) desc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (desc_wr),
        .wr_idx     (desc_wr_idx),
        .wr_ptr     (desc_wr_ptr),
        .wr_size_m1 (desc_wr_size_m1),
        .wr_irq     (desc_wr_irq),
        .rd_idx     (prod_idx),
        .rd_ptr     (d_ptr),
        .rd_size_m1 (d_size_m1),
        .rd_irq     (d_irq)
    );

    rxr_ring_index #(
        .N_DESC (N_DESC),
        .IDX_W  (IDX_W)
    ) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst),
        .step      (step),
        .cons_idx  (cons_idx),
        .prod_idx  (prod_idx),
        .slot_free (slot_free)
    );

    // Fragment bookkeeping shared by the next-state and output logic.
    always_comb begin
        rx_on    = mac_en && path_en;
        accept   = rx_valid && rx_ready;
        size_cnt = CNT_W'(d_size_m1) + CNT_W'(1);
        if (state_q == ST_FILL) begin
            cnt_next = cnt_q + CNT_W'(1);
            byte_off = AW'(cnt_q);
        end else begin
            cnt_next = CNT_W'(1);
            byte_off = '0;
        end
        buf_full = (cnt_next == size_cnt);
        start_ok = (state_q == ST_IDLE) ? (rx_on && slot_free) : slot_free;
        stat_word = '0;
        stat_word[STAT_CNT_W-1:0] = STAT_CNT_W'(cnt_q);
        stat_word[STAT_LAST_BIT]  = last_q;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CONT: begin
                if (accept) begin
                    if (start_ok) begin
                        state_d = (rx_last || buf_full) ? ST_STATUS : ST_FILL;
                    end else if (!rx_last) begin
                        state_d = ST_DROP;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FILL: begin
                if (accept && (rx_last || buf_full)) begin
                    state_d = ST_STATUS;
                end
            end
            ST_STATUS: begin
                state_d = last_q ? ST_IDLE : ST_CONT;
            end
            ST_DROP: begin
                if (accept && rx_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        rx_ready  = 1'b1;
        byte_wr   = 1'b0;
        ovr_set   = 1'b0;
        step      = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b0;
        mem_addr  = d_ptr + byte_off;
        mem_wdata = {24'h0, rx_data};
        unique case (state_q)
            ST_IDLE: begin
                byte_wr = accept && start_ok;
                ovr_set = accept && rx_on && !slot_free;
            end
            ST_CONT: begin
                byte_wr = accept && start_ok;
                ovr_set = accept && !slot_free;
            end
            ST_FILL: begin
                byte_wr = accept;
            end
            ST_STATUS: begin
                rx_ready  = 1'b0;
                step      = 1'b1;
                mem_word  = 1'b1;
                mem_addr  = stat_base + (AW'(prod_idx) << 2);
                mem_wdata = stat_word;
            end
            ST_DROP: begin
            end
            default: begin
            end
        endcase
        mem_we = byte_wr || step;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (soft_rst) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            irq_q <= step && d_irq;
            if (byte_wr) begin
                cnt_q  <= cnt_next;
                last_q <= rx_last;
            end
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign frag_irq = irq_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
    parameter int N_DESC = 8,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             rx_ready,
    input logic             mem_we,
    input logic             mem_word,
    input logic [IDX_W-1:0] prod_idx,
    input logic             frag_irq,
    input logic             overrun
);
    function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(N_DESC - 1)) ? '0 : v + IDX_W'(1);
    endfunction

    assert_status_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_word) |-> !rx_ready);

    assert_index_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_word && !soft_rst) |=> (prod_idx == ring_inc($past(prod_idx))));

    assert_index_only_after_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(mem_we && mem_word)) |=> $stable(prod_idx));

    assert_irq_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frag_irq |-> ($past(mem_we && mem_word) && !$past(soft_rst)));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frag_irq |=> !frag_irq);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !soft_rst) |=> overrun);

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (prod_idx == '0 && !overrun && !frag_irq));
endmodule

bind rxring_writer rxring_writer_chk #(
    .N_DESC (N_DESC),
    .IDX_W  (IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rx_ready (rx_ready),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .prod_idx (prod_idx),
    .frag_irq (frag_irq),
    .overrun  (overrun)
);

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam logic [31:0] SBASE = 32'h8000_0000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, soft_rst = 1'b0, mac_en = 1'b0, path_en = 1'b0;
    logic        desc_wr = 1'b0, desc_wr_irq = 1'b0;
    logic [IW-1:0] desc_wr_idx = '0, cons_idx = '0;
    logic [31:0] desc_wr_ptr = '0, stat_base = SBASE;
    logic [10:0] desc_wr_size_m1 = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, mem_we, mem_word, frag_irq, overrun;
    logic [31:0] mem_addr, mem_wdata;
    logic [IW-1:0] prod_idx;

    rxring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mac_en(mac_en), .path_en(path_en),
        .desc_wr(desc_wr), .desc_wr_idx(desc_wr_idx), .desc_wr_ptr(desc_wr_ptr),
        .desc_wr_size_m1(desc_wr_size_m1), .desc_wr_irq(desc_wr_irq),
        .stat_base(stat_base), .cons_idx(cons_idx),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .prod_idx(prod_idx), .frag_irq(frag_irq), .overrun(overrun)
    );

    int total = 0, bad = 0, irq_seen = 0, exp_irq = 0;
    logic [64:0] exp_q[$];
    logic [64:0] mon_e;
    logic [31:0] m_ptr[N];
    int          m_size[N];
    bit          m_irq[N];
    int          m_prod = 0, m_cons = 0;
    bit          m_ovr = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every memory write against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frag_irq) irq_seen++;
            if (mem_we) begin
                if (mem_word) chk(rx_ready == 1'b0, "R9", "ready during status", rx_ready, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write addr", mem_addr, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk({mem_word, mem_addr, mem_wdata} == mon_e, mem_word ? "R4" : "R2",
                        "write {kind,addr,data}", {mem_word, mem_addr, mem_wdata}, mon_e);
                end
            end
        end
    end

    task automatic desc_write(int idx, logic [31:0] ptr, int size, bit irq);
        desc_wr = 1'b1; desc_wr_idx = IW'(idx); desc_wr_ptr = ptr;
        desc_wr_size_m1 = 11'(size - 1); desc_wr_irq = irq;
        @(posedge clk); #1;
        desc_wr = 1'b0;
        m_ptr[idx] = ptr; m_size[idx] = size; m_irq[idx] = irq;
    endtask

    task automatic send_byte(logic [7:0] d, bit last);
        rx_valid = 1'b1; rx_data = d; rx_last = last;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // Driver: model the frame, push expected writes, then drive the bytes.
    task automatic send_frame(int len, int base);
        int cur = m_prod;
        int cnt = 0;
        bit need = 1'b1, dropping = 1'b0;
        bit en = mac_en && path_en;
        for (int i = 0; i < len; i++) begin
            bit last = (i == len - 1);
            if (!dropping && need) begin
                if (i == 0 && !en) dropping = 1'b1;
                else if (((cur + 1) % N) == m_cons) begin dropping = 1'b1; m_ovr = 1'b1; end
                else begin need = 1'b0; cnt = 0; end
            end
            if (!dropping) begin
                exp_q.push_back({1'b0, m_ptr[cur] + 32'(cnt), 24'h0, 8'(base + i)});
                cnt++;
                if (last || cnt == m_size[cur]) begin
                    exp_q.push_back({1'b1, SBASE + 32'(cur * 4), last, 15'h0, 16'(cnt)});
                    if (m_irq[cur]) exp_irq++;
                    cur = (cur + 1) % N;
                    need = 1'b1;
                end
            end
        end
        m_prod = cur;
        for (int i = 0; i < len; i++) send_byte(8'(base + i), i == len - 1);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic check_state(string req);
        @(negedge clk);
        chk(prod_idx == IW'(m_prod), req, "prod_idx", prod_idx, m_prod);
        chk(overrun == m_ovr, req, "overrun", overrun, m_ovr);
        chk(irq_seen == exp_irq, req, "irq pulses", irq_seen, exp_irq);
        chk(exp_q.size() == 0, req, "writes still pending", exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(prod_idx == '0, "R1", "prod after reset", prod_idx, 0);
        chk(!overrun && !frag_irq, "R1", "flags after reset", {overrun, frag_irq}, 0);
        chk(rx_ready && !mem_we, "R1", "ready/we after reset", {rx_ready, mem_we}, 2);
        @(posedge clk); #1;

        desc_write(0, 32'h1000, 4, 1);
        desc_write(1, 32'h1100, 16, 0);
        desc_write(2, 32'h1200, 4, 1);
        desc_write(3, 32'h1300, 4, 0);
        desc_write(4, 32'h1400, 8, 1);
        desc_write(5, 32'h1500, 4, 1);
        desc_write(6, 32'h1600, 4, 0);
        desc_write(7, 32'h1700, 8, 1);

        // R3: both enables off, then only one enable
        send_frame(3, 8'h10);
        check_state("R3");
        mac_en = 1'b1;
        send_frame(3, 8'h18);
        check_state("R3");
        path_en = 1'b1;

        // R2 R4 R6: short frame into a 4-byte buffer with interrupt
        send_frame(3, 8'h20);
        check_state("R6");
        // R4: single-buffer frame, no interrupt flag
        send_frame(10, 8'h30);
        check_state("R4");
        // R7: frame spans three descriptors
        send_frame(9, 8'h40);
        check_state("R7");
        // R4: frame exactly fills its buffer
        send_frame(4, 8'h50);
        check_state("R4");
        // R8: ring fills in the middle of a frame
        send_frame(6, 8'h60);
        check_state("R8");
        // R8: ring still full at frame start
        send_frame(3, 8'h70);
        check_state("R8");
        // R11: software frees space, index wraps to 0
        cons_idx = IW'(4); m_cons = 4;
        send_frame(2, 8'h80);
        check_state("R11");
        send_frame(3, 8'h90);
        check_state("R5");

        // R10: soft reset in the middle of a frame
        exp_q.push_back({1'b0, m_ptr[1], 24'h0, 8'hA0});
        exp_q.push_back({1'b0, m_ptr[1] + 32'd1, 24'h0, 8'hA1});
        send_byte(8'hA0, 1'b0);
        send_byte(8'hA1, 1'b0);
        soft_rst = 1'b1;
        cons_idx = '0; m_cons = 0;
        @(posedge clk); #1;
        soft_rst = 1'b0;
        m_prod = 0; m_ovr = 1'b0;
        check_state("R10");
        send_frame(5, 8'hB0);
        check_state("R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule